// File: doc/BRIEF.md
# Serial Data Output Unit

This block is the outgoing half of a 16-bit-frame serial slave for a converter. It captures the serial input word. It also drives two general-purpose output pins. Each pin is set up on its own. In readback mode, a pin presents a word that was loaded beforehand by a decoded read command, and it is undriven outside that frame. In the two chain modes, a pin passes the bit leaving the input shift register on to the next device in a daisy chain, and it is held driven high whenever it has nothing to pass on.

The serial clock, chip select and data input are sampled by the system clock, so every event happens in a single clock domain. A frame closes on one of two events: the deassertion of chip select, or the sixteenth rising serial-clock edge, chosen by `end_on_count`. When a frame closes, the captured word is presented together with a one-cycle valid strobe.

Top module: `serial_dout_unit`

## Requirements
- R1: After reset, frame_valid is 0 and no pin drives readback data. A pin in readback mode has its enable low, and a pin in a chain mode is enabled and high.
- R2: While cs_n is low, each rising sclk edge shifts din into the input register, most significant bit first. With end_on_count=0, frame_word equals the last 16 bits received when the frame closes.
- R3: With end_on_count=1, a frame closes on its 16th rising sclk edge and frame_word equals the first 16 bits. With end_on_count=0, it closes when cs_n rises. Each frame gives exactly one frame_valid pulse, one cycle long.
- R4: A pulse on rd_load stores rd_word. In the next frame, a readback pin (mode code 00, or 11, which acts the same) drives that word MSB first from the moment cs_n falls, and it moves on one bit at each falling sclk edge.
- R5: Readback data is driven only in the first frame that starts after rd_load. If rd_load arrives during a frame, it affects only the following frame. In any other frame, a readback pin keeps its enable low.
- R6: A readback pin's enable returns low within two clock cycles after cs_n rises, and it stays low while cs_n is high.
- R7: A chain pin (mode 01 or 10) is always enabled. It reads 1 while cs_n is high and until 16 rising sclk edges have been seen in the current frame.
- R8: In mode 01, the chain pin updates on falling sclk edges. After the k-th falling edge of a frame, with k of 16 or more, it carries stream bit k-16, counting from 0. Bits beyond 16 keep flowing through.
- R9: In mode 10, the chain pin updates on rising sclk edges. From the 17th rising edge on, after the k-th falling edge it carries stream bit k-17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock, sampled |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in |
| end_on_count | input | 1 | 1: frame closes on 16th edge; 0: on cs_n rise |
| pin_mode | input | 4 | Two bits per pin, pin p at [2p+1:2p]: 00 readback, 01 chain/falling, 10 chain/rising, 11 readback |
| rd_load | input | 1 | Read-command strobe, loads rd_word |
| rd_word | input | 16 | Readback data |
| dout | output | 2 | Pin values |
| dout_oe | output | 2 | Pin output enables |
| frame_word | output | 16 | Captured frame word |
| frame_valid | output | 1 | One-cycle end-of-frame strobe |

## Verification
The chain modes are driven with 32-bit frames built from mixed words and from alternating all-ones and all-zeros words. These frames show whether the pin idles high for exactly the right number of edges, and whether it updates on the falling edge or the rising edge. A one-bit shift between the two chain modes shows up directly as a mismatch. Readback is tried with a load before a frame, with a frame that has no load, and with a load in the middle of a frame. Together these separate "next frame only" from "any later frame" and from "immediately". Short frames and both frame-end choices show the difference between capturing the first 16 bits and capturing the last 16 bits.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
  typedef enum logic [1:0] {
    PM_READBACK = 2'b00,
    PM_CHAIN_F  = 2'b01,
    PM_CHAIN_R  = 2'b10,
    PM_RB_ALT   = 2'b11
  } pin_mode_e;

  function automatic logic is_chain(pin_mode_e m);
    return (m == PM_CHAIN_F) || (m == PM_CHAIN_R);
  endfunction

  function automatic logic pin_enable(pin_mode_e m, logic rb_on);
    return is_chain(m) ? 1'b1 : rb_on;
  endfunction

  function automatic logic pin_value(pin_mode_e m, logic rb_bit,
                                     logic dc_fall, logic dc_rise);
    case (m)
      PM_CHAIN_F: return dc_fall;
      PM_CHAIN_R: return dc_rise;
      default:    return rb_bit;
    endcase
  endfunction
endpackage

// File: rtl/sdu_shift_core.sv
module sdu_shift_core #(
  parameter int FRAME_W = 16,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               din,
  input  logic               end_on_count,
  output logic               cs_q,
  output logic               rise_ev,
  output logic               fall_ev,
  output logic               cs_fall_ev,
  output logic               full,
  output logic               sr_msb,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_valid
);
  logic               sclk_q, sclk_qq, cs_qq, din_q;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               cs_rise_ev, last_edge;

  function automatic logic [FRAME_W-1:0] shift_in(logic [FRAME_W-1:0] v, logic b);
    return {v[FRAME_W-2:0], b};
  endfunction

  assign rise_ev    = sclk_q & ~sclk_qq;
  assign fall_ev    = ~sclk_q & sclk_qq;
  assign cs_fall_ev = ~cs_q & cs_qq;
  assign cs_rise_ev = cs_q & ~cs_qq;
  assign full       = (cnt == CNT_W'(FRAME_W));
  assign last_edge  = rise_ev & ~cs_q & (cnt == CNT_W'(FRAME_W - 1));
  assign sr_msb     = sr[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b1;
      cs_qq   <= 1'b1;
      din_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sclk_qq <= sclk_q;
      cs_q    <= cs_n;
      cs_qq   <= cs_q;
      din_q   <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cs_q) begin
      cnt <= '0;
    end else if (rise_ev) begin
      sr <= shift_in(sr, din_q);
      if (!full) cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_word  <= '0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (end_on_count && last_edge) begin
        frame_word  <= shift_in(sr, din_q);
        frame_valid <= 1'b1;
      end else if (!end_on_count && cs_rise_ev) begin
        frame_word  <= sr;
        frame_valid <= 1'b1;
      end
    end
  end

  // R2
  shift_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && !cs_q) |=> (sr[0] == $past(din_q)));

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
endmodule

// File: rtl/sdu_readback.sv
module sdu_readback #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_load,
  input  logic [FRAME_W-1:0] rd_word,
  input  logic               cs_q,
  input  logic               cs_fall_ev,
  input  logic               fall_ev,
  output logic               rb_active,
  output logic               rb_bit
);
  logic               armed;
  logic [FRAME_W-1:0] hold, shreg;

  assign rb_bit = shreg[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      hold  <= '0;
    end else if (rd_load) begin
      armed <= 1'b1;
      hold  <= rd_word;
    end else if (cs_fall_ev) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_active <= 1'b0;
      shreg     <= '0;
    end else if (cs_q) begin
      rb_active <= 1'b0;
    end else if (cs_fall_ev) begin
      rb_active <= armed;
      shreg     <= hold;
    end else if (fall_ev && rb_active) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  // R6
  rb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && $past(cs_q)) |-> !rb_active);

  // R5
  rb_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall_ev && !armed) |=> !rb_active);
endmodule

// File: rtl/sdu_chain_tap.sv
module sdu_chain_tap (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_q,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic full,
  input  logic sr_msb,
  output logic dc_fall,
  output logic dc_rise
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_fall <= 1'b1;
      dc_rise <= 1'b1;
    end else if (cs_q) begin
      dc_fall <= 1'b1;
      dc_rise <= 1'b1;
    end else begin
      if (fall_ev && full) dc_fall <= sr_msb;
      if (rise_ev && full) dc_rise <= sr_msb;
    end
  end

  // R7
  chain_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> (dc_fall && dc_rise));

  // R8
  chain_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_ev && !cs_q) |=> (dc_fall == $past(dc_fall)));

  // R9
  chain_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && !cs_q) |=> (dc_rise == $past(dc_rise)));
endmodule

// File: rtl/sdu_pin_drv.sv
module sdu_pin_drv
  import sdu_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       rb_active,
  input  logic       rb_bit,
  input  logic       dc_fall,
  input  logic       dc_rise,
  output logic       pin,
  output logic       pin_oe
);
  pin_mode_e m;
  assign m      = pin_mode_e'(mode);
  assign pin_oe = pin_enable(m, rb_active);
  assign pin    = pin_value(m, rb_bit, dc_fall, dc_rise);
endmodule

// File: rtl/serial_dout_unit.sv
module serial_dout_unit #(
  parameter int FRAME_W = 16,
  parameter int N_PINS  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  din,
  input  logic                  end_on_count,
  input  logic [2*N_PINS-1:0]   pin_mode,
  input  logic                  rd_load,
  input  logic [FRAME_W-1:0]    rd_word,
  output logic [N_PINS-1:0]     dout,
  output logic [N_PINS-1:0]     dout_oe,
  output logic [FRAME_W-1:0]    frame_word,
  output logic                  frame_valid
);
  logic cs_q, rise_ev, fall_ev, cs_fall_ev, full, sr_msb;
  logic rb_active, rb_bit, dc_fall, dc_rise;

  sdu_shift_core #(.FRAME_W(FRAME_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .end_on_count(end_on_count), .cs_q(cs_q), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .cs_fall_ev(cs_fall_ev), .full(full),
    .sr_msb(sr_msb), .frame_word(frame_word), .frame_valid(frame_valid)
  );

  sdu_readback #(.FRAME_W(FRAME_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_word(rd_word),
    .cs_q(cs_q), .cs_fall_ev(cs_fall_ev), .fall_ev(fall_ev),
    .rb_active(rb_active), .rb_bit(rb_bit)
  );

  sdu_chain_tap u_tap (
    .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .rise_ev(rise_ev),
    .fall_ev(fall_ev), .full(full), .sr_msb(sr_msb),
    .dc_fall(dc_fall), .dc_rise(dc_rise)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    sdu_pin_drv u_drv (
      .mode(pin_mode[2*g+1:2*g]), .rb_active(rb_active), .rb_bit(rb_bit),
      .dc_fall(dc_fall), .dc_rise(dc_rise),
      .pin(dout[g]), .pin_oe(dout_oe[g])
    );
  end
endmodule

// File: tb/tb_serial_dout_unit.sv
module tb_serial_dout_unit;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, din = 0, end_on_count = 0;
  logic [3:0]  pin_mode = 4'b0100;
  logic        rd_load = 0;
  logic [15:0] rd_word = '0;
  logic [1:0]  dout, dout_oe;
  logic [15:0] frame_word;
  logic        frame_valid;
  int checks = 0, errors = 0, vcnt = 0;
  logic [15:0] cap_word;
  bit done = 0;

  serial_dout_unit dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .end_on_count(end_on_count), .pin_mode(pin_mode), .rd_load(rd_load),
    .rd_word(rd_word), .dout(dout), .dout_oe(dout_oe),
    .frame_word(frame_word), .frame_valid(frame_valid)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (frame_valid) begin
    vcnt++;
    cap_word = frame_word;
  end

  // rows: pin0 mode, pin1 mode, end_on_count, word A, word B
  localparam logic [36:0] VEC [4] = '{
    {2'b01, 2'b10, 1'b0, 16'hA5C3, 16'h0F96},
    {2'b10, 2'b00, 1'b1, 16'h8001, 16'h7FFE},
    {2'b11, 2'b01, 1'b1, 16'hFFFF, 16'h0000},
    {2'b01, 2'b01, 1'b0, 16'h3C5A, 16'hC3A5}
  };

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_bit(logic b);
    din = b; sclk = 1; wait_clk(4);
    sclk = 0; wait_clk(4);
  endtask

  task automatic check(logic ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic chain_exp(logic [1:0] m, int n, logic [31:0] s);
    int lag = (m == 2'b01) ? 15 : 16;
    return (n < lag) ? 1'b1 : s[31 - (n - lag)];
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mis;
    wait_clk(3);
    rst_n = 1;
    wait_clk(3);
    // R1 reset state
    check(dout_oe[0] == 0, "R1 readback oe", dout_oe[0], 0);
    check(dout_oe[1] == 1 && dout[1] == 1, "R1 chain idle", {dout_oe[1], dout[1]}, 2'b11);
    check(frame_valid == 0 && vcnt == 0, "R1 valid", vcnt, 0);

    // R4 readback after load
    rd_word = 16'hB2E7; rd_load = 1; wait_clk(1); rd_load = 0; wait_clk(2);
    vcnt = 0;
    cs_n = 0; wait_clk(4);
    check(dout_oe[0] == 1, "R4 oe in frame", dout_oe[0], 1);
    mis = 0;
    for (int k = 0; k < 16; k++) begin
      if (dout[0] !== rd_word[15-k]) mis++;
      do_bit(1'(16'h1234 >> (15 - k)));
    end
    check(mis == 0, "R4 readback stream", mis, 0);
    cs_n = 1; wait_clk(3);
    check(dout_oe[0] == 0, "R6 oe after cs high", dout_oe[0], 0);
    wait_clk(3);
    check(cap_word == 16'h1234 && vcnt == 1, "R2 frame word", cap_word, 16'h1234);

    // R5 frame without load, load mid-frame
    cs_n = 0; wait_clk(4);
    check(dout_oe[0] == 0, "R5 no load frame", dout_oe[0], 0);
    rd_word = 16'h6D19; rd_load = 1; wait_clk(1); rd_load = 0;
    mis = 0;
    for (int k = 0; k < 16; k++) begin
      do_bit(1'(k));
      if (dout_oe[0]) mis++;
      if (dout[1] !== 1'b1 && k < 14) mis++;
    end
    check(mis == 0, "R5 mid-frame load deferred", mis, 0);
    cs_n = 1; wait_clk(4);
    cs_n = 0; wait_clk(4);
    check(dout_oe[0] == 1 && dout[0] == 0, "R5 next frame", {dout_oe[0], dout[0]}, 2'b10);
    do_bit(1'b0);
    check(dout[0] == 1, "R4 second bit", dout[0], 1);
    cs_n = 1; wait_clk(4);
    cs_n = 0; wait_clk(4);
    check(dout_oe[0] == 0, "R5 only one frame", dout_oe[0], 0);
    cs_n = 1; wait_clk(4);

    // R7 short chain frame
    cs_n = 0; wait_clk(4);
    mis = 0;
    for (int k = 0; k < 8; k++) begin
      do_bit(1'b0);
      if (dout[1] !== 1'b1 || dout_oe[1] !== 1'b1) mis++;
    end
    check(mis == 0, "R7 short frame high", mis, 0);
    cs_n = 1; wait_clk(4);

    // table of chain frames
    for (int r = 0; r < 4; r++) begin
      logic [31:0] s;
      logic [1:0] m [2];
      int pm [2];
      m[0] = VEC[r][36:35]; m[1] = VEC[r][34:33];
      end_on_count = VEC[r][32];
      s = VEC[r][31:0];
      pin_mode = {m[1], m[0]};
      wait_clk(2);
      vcnt = 0;
      cs_n = 0; wait_clk(4);
      pm[0] = 0; pm[1] = 0;
      for (int n = 0; n < 32; n++) begin
        do_bit(s[31-n]);
        for (int p = 0; p < 2; p++) begin
          if (m[p] == 2'b01 || m[p] == 2'b10) begin
            if (dout[p] !== chain_exp(m[p], n, s) || !dout_oe[p]) pm[p]++;
          end else if (dout_oe[p]) pm[p]++;
        end
      end
      for (int p = 0; p < 2; p++) begin
        if (m[p] == 2'b01)      check(pm[p] == 0, "R8 chain falling", pm[p], 0);
        else if (m[p] == 2'b10) check(pm[p] == 0, "R9 chain rising", pm[p], 0);
        else                    check(pm[p] == 0, "R5 unloaded readback", pm[p], 0);
      end
      cs_n = 1; wait_clk(6);
      if (end_on_count)
        check(cap_word == s[31:16] && vcnt == 1, "R3 first word", cap_word, s[31:16]);
      else
        check(cap_word == s[15:0] && vcnt == 1, "R3 last word", cap_word, s[15:0]);
      for (int p = 0; p < 2; p++)
        if (m[p] == 2'b01 || m[p] == 2'b10)
          check(dout[p] == 1 && dout_oe[p] == 1, "R7 idle high", dout[p], 1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule